// File: doc/BRIEF.md
# On-off keyed packet waveform transmitter

This block drives the data pin of a low-cost on-off keyed RF transmitter from a packet held in a byte buffer elsewhere on chip. A start strobe launches a frame. Each repetition of the frame sends four things in turn. First comes a square-wave preamble, which lets the receiver's gain control settle. Next comes a long synchronisation high followed by an equally long low. Then the packet bits are sent as pulse-width-coded high/low pairs. Last, the line is held low for a gap.

The frame is sent a fixed number of times. The packet is re-read from the buffer for every repetition. Each bit is a high phase followed by a low phase of the same length, and only that length carries the bit value. This keeps the line near 50% duty cycle throughout. All durations are counted in ticks of an internal divider, which is nominally 1 µs. The divider restarts with each frame, so every phase is an exact multiple of the divider period.

Top module: `ook_frame_tx`

## Requirements
- R1: After reset `tx_o` and `busy_o` are 0, and `tx_o` is 0 in every cycle in which `busy_o` is 0.
- R2: A `start_i` seen while idle sets `busy_o` and `tx_o` in the next cycle. Each repetition opens with TRAIN_CYCLES periods of T_HALF ticks high then T_HALF ticks low.
- R3: After the preamble, the line is high for T_SYNC ticks and then low for T_SYNC ticks.
- R4: A bit value 0 is sent as T_ZERO ticks high then T_ZERO ticks low. A bit value 1 is sent as T_ONE ticks high then T_ONE ticks low.
- R5: Bytes are sent from index 0 upward, for exactly the `len_i` bytes captured at start, each byte most significant bit first. `rd_addr_o` carries the byte index, and `rd_data_i` is used in the same cycle.
- R6: After the last bit, the line is low for T_GAP ticks. With a length of 0, the sync low is followed directly by the gap.
- R7: The frame is sent REPEATS times in all. `busy_o` falls in the cycle after the final gap ends, and the line then stays low.
- R8: `start_i` has no effect while `busy_o` is 1, even in the last busy cycle. `len_i` is sampled only when a start is accepted.
- R9: One tick is CLK_DIV clock cycles, counted from the accepting edge. A phase of N ticks therefore lasts exactly N·CLK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame launch strobe |
| len_i | input | LEN_W | Packet length in bytes (0..MAX_BYTES) |
| rd_addr_o | output | ADDR_W | Byte index into the packet buffer |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, combinational |
| busy_o | output | 1 | High from an accepted start until the final gap ends |
| tx_o | output | 1 | Keyed line to the transmitter |

## Verification
Two events can fall in the same cycle. One is the end of the final gap, which returns the block to idle. The other is a new start strobe. The bench raises `start_i` in exactly the last busy cycle of a frame. In the following cycle it requires `busy_o` and `tx_o` to be low, which shows that the strobe was dropped rather than queued. A second case raises `start_i` and changes `len_i` mid-frame, and then judges the remaining waveform against the length captured at launch.

// File: rtl/ook_tx_pkg.sv
package ook_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIN_HI,
    ST_TRAIN_LO,
    ST_SYNC_HI,
    ST_SYNC_LO,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_GAP
  } ook_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic state_is_high(input ook_state_e s);
    return (s == ST_TRAIN_HI) || (s == ST_SYNC_HI) || (s == ST_BIT_HI);
  endfunction

endpackage

// File: rtl/ook_tick_gen.sv
module ook_tick_gen #(
  parameter int unsigned CLK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned DivW = $clog2(CLK_DIV);
      localparam logic [DivW-1:0] DivLast = DivW'(CLK_DIV - 1);
      logic [DivW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (!en_i || cnt_q == DivLast) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick_o = en_i && (cnt_q == DivLast);
    end
  endgenerate

endmodule

// File: rtl/ook_seg_timer.sv
module ook_seg_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o
);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= load_val_i;
    end else if (tick_i && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign done_o = tick_i && (rem_q == CNT_W'(1));

endmodule

// File: rtl/ook_frame_seq.sv
module ook_frame_seq
  import ook_tx_pkg::*;
#(
  parameter int unsigned REPEATS      = 3,
  parameter int unsigned TRAIN_CYCLES = 20,
  parameter int unsigned T_HALF       = 200,
  parameter int unsigned T_SYNC       = 2000,
  parameter int unsigned T_ZERO       = 300,
  parameter int unsigned T_ONE        = 500,
  parameter int unsigned T_GAP        = 5000,
  parameter int unsigned LEN_W        = 6,
  parameter int unsigned CNT_W        = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       rd_data_i,
  input  logic             seg_done_i,
  output logic             seg_load_o,
  output logic [CNT_W-1:0] seg_val_o,
  output logic [LEN_W-1:0] byte_o,
  output logic [LEN_W-1:0] len_o,
  output logic             busy_o,
  output logic             tx_o
);

  localparam int unsigned RepW = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam int unsigned TrW  = (TRAIN_CYCLES > 1) ? $clog2(TRAIN_CYCLES) : 1;
  localparam logic [RepW-1:0] RepLast = RepW'(REPEATS - 1);
  localparam logic [TrW-1:0]  TrLast  = TrW'(TRAIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] DHalf = CNT_W'(T_HALF);
  localparam logic [CNT_W-1:0] DSync = CNT_W'(T_SYNC);
  localparam logic [CNT_W-1:0] DZero = CNT_W'(T_ZERO);
  localparam logic [CNT_W-1:0] DOne  = CNT_W'(T_ONE);
  localparam logic [CNT_W-1:0] DGap  = CNT_W'(T_GAP);

  ook_state_e       state_q, state_d;
  logic [RepW-1:0]  rep_q;
  logic [TrW-1:0]   train_q;
  logic [LEN_W-1:0] byte_q, len_q;
  logic [2:0]       bit_q;
  logic             bit_val_q;
  logic             cur_bit;

  assign cur_bit = rd_data_i[bit_q];

  always_comb begin
    state_d    = state_q;
    seg_load_o = 1'b0;
    seg_val_o  = DHalf;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_TRAIN_HI; seg_load_o = 1'b1; seg_val_o = DHalf;
      end
      ST_TRAIN_HI: if (seg_done_i) begin
        state_d = ST_TRAIN_LO; seg_load_o = 1'b1; seg_val_o = DHalf;
      end
      ST_TRAIN_LO: if (seg_done_i) begin
        seg_load_o = 1'b1;
        if (train_q == TrLast) begin
          state_d = ST_SYNC_HI; seg_val_o = DSync;
        end else begin
          state_d = ST_TRAIN_HI; seg_val_o = DHalf;
        end
      end
      ST_SYNC_HI: if (seg_done_i) begin
        state_d = ST_SYNC_LO; seg_load_o = 1'b1; seg_val_o = DSync;
      end
      ST_SYNC_LO, ST_BIT_LO: if (seg_done_i) begin
        seg_load_o = 1'b1;
        if (byte_q == len_q) begin
          state_d = ST_GAP; seg_val_o = DGap;
        end else begin
          state_d = ST_BIT_HI; seg_val_o = cur_bit ? DOne : DZero;
        end
      end
      ST_BIT_HI: if (seg_done_i) begin
        state_d = ST_BIT_LO; seg_load_o = 1'b1;
        seg_val_o = bit_val_q ? DOne : DZero;
      end
      ST_GAP: if (seg_done_i) begin
        if (rep_q == RepLast) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_TRAIN_HI; seg_load_o = 1'b1; seg_val_o = DHalf;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rep_q     <= '0;
      train_q   <= '0;
      byte_q    <= '0;
      len_q     <= '0;
      bit_q     <= 3'd7;
      bit_val_q <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          len_q   <= len_i;
          rep_q   <= '0;
          train_q <= '0;
          byte_q  <= '0;
          bit_q   <= 3'd7;
        end
        ST_TRAIN_LO: if (seg_done_i && train_q != TrLast) train_q <= train_q + 1'b1;
        ST_SYNC_LO, ST_BIT_LO: if (seg_done_i) bit_val_q <= cur_bit;
        // advance the byte at the end of its last high so the next byte is addressed during the low
        ST_BIT_HI: if (seg_done_i) begin
          if (bit_q == 3'd0) begin
            byte_q <= byte_q + 1'b1;
            bit_q  <= 3'd7;
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end
        ST_GAP: if (seg_done_i && rep_q != RepLast) begin
          rep_q   <= rep_q + 1'b1;
          train_q <= '0;
          byte_q  <= '0;
          bit_q   <= 3'd7;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign tx_o   = state_is_high(state_q);
  assign byte_o = byte_q;
  assign len_o  = len_q;

endmodule

// File: rtl/ook_frame_tx.sv
module ook_frame_tx
  import ook_tx_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 50,
  parameter int unsigned REPEATS      = 3,
  parameter int unsigned TRAIN_CYCLES = 20,
  parameter int unsigned T_HALF       = 200,
  parameter int unsigned T_SYNC       = 2000,
  parameter int unsigned T_ZERO       = 300,
  parameter int unsigned T_ONE        = 500,
  parameter int unsigned T_GAP        = 5000,
  parameter int unsigned MAX_BYTES    = 32,
  localparam int unsigned ADDR_W      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int unsigned LEN_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              tx_o
);

  localparam int unsigned MaxT =
    max_u(max_u(max_u(T_HALF, T_SYNC), max_u(T_ZERO, T_ONE)), T_GAP);
  localparam int unsigned CntW = $clog2(MaxT + 1);

  logic             tick;
  logic             seg_load, seg_done;
  logic [CntW-1:0]  seg_val;
  logic [LEN_W-1:0] byte_idx, len_q;

  ook_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  ook_seg_timer #(.CNT_W(CntW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (seg_load),
    .load_val_i (seg_val),
    .tick_i     (tick),
    .done_o     (seg_done)
  );

  ook_frame_seq #(
    .REPEATS      (REPEATS),
    .TRAIN_CYCLES (TRAIN_CYCLES),
    .T_HALF       (T_HALF),
    .T_SYNC       (T_SYNC),
    .T_ZERO       (T_ZERO),
    .T_ONE        (T_ONE),
    .T_GAP        (T_GAP),
    .LEN_W        (LEN_W),
    .CNT_W        (CntW)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len_i),
    .rd_data_i  (rd_data_i),
    .seg_done_i (seg_done),
    .seg_load_o (seg_load),
    .seg_val_o  (seg_val),
    .byte_o     (byte_idx),
    .len_o      (len_q),
    .busy_o     (busy_o),
    .tx_o       (tx_o)
  );

  assign rd_addr_o = byte_idx[ADDR_W-1:0];

endmodule

// File: rtl/ook_frame_tx_chk.sv
module ook_frame_tx_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LEN_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              tx_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              tick_i,
  input logic [LEN_W-1:0]  len_q_i
);

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tx_o);

  // R2
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && tx_o));

  // R9
  edge_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (tx_o != $past(tx_o))) |-> $past(tick_i));

  // R5
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (LEN_W'(rd_addr_o) <= len_q_i));

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> busy_o);

  // R8
  len_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(len_q_i));

  // R7
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(tick_i) && !tx_o));

endmodule

bind ook_frame_tx ook_frame_tx_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .tx_o      (tx_o),
  .rd_addr_o (rd_addr_o),
  .tick_i    (tick),
  .len_q_i   (len_q)
);

// File: tb/test_ook_frame_tx.sv
`timescale 1ns/1ps
module test_ook_frame_tx;

  localparam int unsigned DIV   = 2;
  localparam int unsigned REPS  = 2;
  localparam int unsigned TRN   = 3;
  localparam int unsigned THALF = 3;
  localparam int unsigned TSYNC = 7;
  localparam int unsigned TZERO = 2;
  localparam int unsigned TONE  = 4;
  localparam int unsigned TGAP  = 9;
  localparam int unsigned MAXB  = 4;
  localparam int unsigned AW    = $clog2(MAXB);
  localparam int unsigned LW    = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy, tx;
  logic [7:0]    mem [MAXB];

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign rd_data = mem[rd_addr];

  ook_frame_tx #(
    .CLK_DIV(DIV), .REPEATS(REPS), .TRAIN_CYCLES(TRN), .T_HALF(THALF),
    .T_SYNC(TSYNC), .T_ZERO(TZERO), .T_ONE(TONE), .T_GAP(TGAP), .MAX_BYTES(MAXB)
  ) i_ook_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy), .tx_o(tx)
  );

  // checks one phase of ncyc cycles, one sample per cycle, starting at the current negedge
  task automatic seg(input logic lvl, input int ncyc, input string tag);
    int bad = 0;
    logic bad_tx = 1'b0;
    logic bad_busy = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      if (tx !== lvl || busy !== 1'b1) begin
        if (bad == 0) begin
          bad_tx = tx;
          bad_busy = busy;
        end
        bad++;
      end
      @(negedge clk);
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s phase: tx=%b busy=%b expected tx=%b busy=1", tag, bad_tx, bad_busy, lvl);
    end
  endtask

  task automatic chk_idle(input string tag);
    n_tests++;
    if (tx !== 1'b0 || busy !== 1'b0) begin
      n_fail++;
      $display("FAIL %s idle: tx=%b busy=%b expected tx=0 busy=0", tag, tx, busy);
    end
  endtask

  task automatic run_frame(input int nbytes, input bit inject, input bit late);
    len   = LW'(nbytes);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < int'(REPS); r++) begin
      for (int t = 0; t < int'(TRN); t++) begin
        seg(1'b1, THALF * DIV, "R2 R9");
        seg(1'b0, THALF * DIV, "R2 R9");
      end
      if (inject && r == 0) begin
        start = 1'b1;
        len   = LW'(MAXB - nbytes);
      end
      seg(1'b1, TSYNC * DIV, "R3 R8");
      start = 1'b0;
      seg(1'b0, TSYNC * DIV, "R3");
      for (int b = 0; b < nbytes; b++) begin
        for (int i = 7; i >= 0; i--) begin
          int d = mem[b][i] ? TONE : TZERO;
          seg(1'b1, d * DIV, "R4 R5");
          seg(1'b0, d * DIV, "R4 R5");
        end
      end
      if (late && r == int'(REPS) - 1) begin
        seg(1'b0, TGAP * DIV - 1, "R6");
        start = 1'b1;
        seg(1'b0, 1, "R6 R8");
        start = 1'b0;
        chk_idle("R8");
      end else begin
        seg(1'b0, TGAP * DIV, "R6 R7");
      end
    end
    chk_idle("R7 R1");
    repeat (3) @(negedge clk);
    chk_idle("R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < int'(MAXB); b++) mem[b] = 8'h00;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    // R6: empty packet
    mem[0] = 8'hff;
    run_frame(0, 1'b0, 1'b0);

    // R5: length and ordering sweep
    mem[0] = 8'h81; mem[1] = 8'h3c; mem[2] = 8'ha5; mem[3] = 8'h0f;
    for (int n = 1; n <= int'(MAXB); n++) run_frame(n, 1'b0, 1'b0);
    mem[0] = 8'h00; mem[1] = 8'hff; mem[2] = 8'h5a; mem[3] = 8'hc3;
    run_frame(MAXB, 1'b0, 1'b0);

    // R4: every single-byte value
    for (int v = 0; v < 256; v++) begin
      mem[0] = 8'(v);
      run_frame(1, 1'b0, 1'b0);
    end

    // R8: start and length change while busy
    mem[0] = 8'h96; mem[1] = 8'h71;
    run_frame(2, 1'b1, 1'b0);

    // R8: start in the final busy cycle
    run_frame(1, 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule